// File: doc/BRIEF.md
# Single-channel DMA address engine

This block is one channel of a DMA controller. A CPU-side write port programs its sizes, signed steps, mode bits and the shadow copies of its begin and current addresses. Once software sets the run bit, each latched peripheral trigger makes the channel move words over a zero-wait memory bus. Every word is one read cycle at the source address and then one write cycle at the destination address, carrying the data that was read.

Each side (source and destination) computes its address from three nested loops. Within a burst, the address steps by a signed per-word amount. Between bursts, it steps by a signed transfer amount. Every N bursts it wraps instead: the address reloads from a wrap base plus a signed wrap step, and that sum becomes the new base. The channel can run a whole transfer on one trigger, or a single burst per trigger. It can stop at the end of a transfer or re-arm. It can raise a one-cycle interrupt when a transfer starts or when it ends. A trigger that lands on one still pending sets an overflow flag.

Top module: `dma_ch`

## Requirements
- R1: After reset, run_o, ovf_o, irq_o, ovf_irq_o, bus_rd_o and bus_wr_o are all 0.
- R2: Each word is one cycle with bus_rd_o high at the source address, followed in the next cycle by bus_wr_o high at the destination address with bus_wdata_o equal to bus_rdata_i from the read cycle. bus_wide_o follows mode bit 3 (1 = 32-bit moves). Addresses count 16-bit units, so 32-bit moves use steps of 2.
- R3: Register 2 holds words per burst minus one. Register 3 holds bursts per transfer minus one.
- R4: Within a burst, after every word except the last, the source address advances by register 4 and the destination address by register 5. Both steps are 16-bit signed values.
- R5: At the end of a burst, a side that does not wrap advances by its signed transfer step (register 6 for source, 7 for destination). A side that wraps does not apply its transfer step. Addresses roll over modulo 2^ADDR_W.
- R6: Registers 8 and 9 hold the bursts between wraps minus one, for source and destination. When a side's wrap count expires at a burst end, its address becomes base plus its signed wrap step (register 10 or 11), and its base takes that same value.
- R7: Registers 12 and 13 hold the source begin and current shadows, and 14 and 15 the destination ones. The shadows are copied into the working address, base and wrap count only when a new transfer starts. Writing them during a transfer has no effect on that transfer.
- R8: With mode bit 1 (one-shot) set, one trigger runs the whole transfer. With it clear, each trigger moves exactly one burst.
- R9: When a transfer ends, run_o drops unless mode bit 2 (continuous) is set. In continuous mode the channel stays armed, and the next trigger starts a new transfer from the shadows.
- R10: With mode bit 4 set, irq_o pulses for one cycle per transfer. With mode bit 5 clear, the pulse comes together with the first read. With mode bit 5 set, it comes in the cycle after the last write. With mode bit 4 clear, irq_o stays low.
- R11: A trigger that arrives while an earlier one is still pending sets ovf_o. ovf_irq_o equals ovf_o only while mode bit 6 is set. Writing 1 to bit 2 of register 0 discards a pending trigger, and writing 1 to bit 3 clears ovf_o.
- R12: Writing 1 to bit 1 of register 0 (hard reset) brings run_o, ovf_o, the pending trigger and all counters to idle on the next cycle, and stops bus activity.
- R13: Writing 1 to bit 0 of register 0 sets run. trig_i is latched only while mode bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| trig_i | input | 1 | Peripheral trigger |
| bus_rd_o | output | 1 | Read cycle at bus_addr_o |
| bus_wr_o | output | 1 | Write cycle at bus_addr_o |
| bus_addr_o | output | ADDR_W | Word address, 16-bit units |
| bus_wide_o | output | 1 | 32-bit move when high |
| bus_rdata_i | input | DATA_W | Read data, valid in the read cycle |
| bus_wdata_o | output | DATA_W | Write data |
| run_o | output | 1 | Channel running |
| ovf_o | output | 1 | Trigger overflow flag |
| irq_o | output | 1 | Channel interrupt pulse |
| ovf_irq_o | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with its default parameters: ADDR_W = 22, CNT_W = 16, STEP_W = 16 and DATA_W = 32. With a 22-bit address, a decrementing destination can be driven below zero and checked against the modulo-2^22 value. With a 16-bit wrap size, 0xFFFF keeps wrapping out of the linear tests, while small wrap sizes on the source show a wrap taking the place of the transfer step. Read data is a function of the address, so every write also confirms which source word was read.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RD, ST_WR} ch_state_e;

  localparam logic [3:0] REG_CTRL  = 4'd0;
  localparam logic [3:0] REG_MODE  = 4'd1;
  localparam logic [3:0] REG_BSIZE = 4'd2;
  localparam logic [3:0] REG_TSIZE = 4'd3;
  localparam int REG_BSTEP  = 4;   // +side
  localparam int REG_TSTEP  = 6;
  localparam int REG_WSIZE  = 8;
  localparam int REG_WSTEP  = 10;
  localparam int REG_SHADOW = 12;  // +2*side: begin, +1: current

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HRST = 1;
  localparam int CTRL_PCLR = 2;
  localparam int CTRL_OCLR = 3;

  typedef struct packed {
    logic ovf_ie;   // bit 6
    logic at_end;   // bit 5
    logic irq_en;   // bit 4
    logic wide;     // bit 3
    logic cont;     // bit 2
    logic oneshot;  // bit 1
    logic trig_en;  // bit 0
  } mode_t;
endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 16,
  parameter int STEP_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [3:0]                  addr_i,
  input  logic [31:0]                 wdata_i,
  output logic                        run_set_o,
  output logic                        hard_rst_o,
  output logic                        pend_clr_o,
  output logic                        ovf_clr_o,
  output mode_t                       mode_o,
  output logic [CNT_W-1:0]            bsize_o,
  output logic [CNT_W-1:0]            tsize_o,
  output logic [1:0][STEP_W-1:0]      bstep_o,
  output logic [1:0][STEP_W-1:0]      tstep_o,
  output logic [1:0][STEP_W-1:0]      wstep_o,
  output logic [1:0][CNT_W-1:0]       wsize_o,
  output logic [1:0][ADDR_W-1:0]      sh_beg_o,
  output logic [1:0][ADDR_W-1:0]      sh_addr_o
);
  logic ctrl_hit;
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
  assign ctrl_hit   = we_i && addr_i == REG_CTRL;
  assign run_set_o  = ctrl_hit && wdata_i[CTRL_RUN];
  assign hard_rst_o = ctrl_hit && wdata_i[CTRL_HRST];
  assign pend_clr_o = ctrl_hit && wdata_i[CTRL_PCLR];
  assign ovf_clr_o  = ctrl_hit && wdata_i[CTRL_OCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= '0;
      bsize_o   <= '0;
      tsize_o   <= '0;
      bstep_o   <= '0;
      tstep_o   <= '0;
      wstep_o   <= '0;
      wsize_o   <= '0;
      sh_beg_o  <= '0;
      sh_addr_o <= '0;
    end else if (we_i) begin
      if (addr_i == REG_MODE)  mode_o  <= mode_t'(wdata_i[6:0]);
      if (addr_i == REG_BSIZE) bsize_o <= wdata_i[CNT_W-1:0];
      if (addr_i == REG_TSIZE) tsize_o <= wdata_i[CNT_W-1:0];
      for (int s = 0; s < 2; s++) begin
        if (addr_i == 4'(REG_BSTEP + s))      bstep_o[s]   <= wdata_i[STEP_W-1:0];
        if (addr_i == 4'(REG_TSTEP + s))      tstep_o[s]   <= wdata_i[STEP_W-1:0];
        if (addr_i == 4'(REG_WSIZE + s))      wsize_o[s]   <= wdata_i[CNT_W-1:0];
        if (addr_i == 4'(REG_WSTEP + s))      wstep_o[s]   <= wdata_i[STEP_W-1:0];
        if (addr_i == 4'(REG_SHADOW + 2*s))   sh_beg_o[s]  <= wdata_i[ADDR_W-1:0];
        if (addr_i == 4'(REG_SHADOW + 2*s+1)) sh_addr_o[s] <= wdata_i[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_addr_side.sv
module dma_addr_side #(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 16,
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              word_step_i,
  input  logic              burst_end_i,
  input  logic [ADDR_W-1:0] sh_beg_i,
  input  logic [ADDR_W-1:0] sh_addr_i,
  input  logic [STEP_W-1:0] bstep_i,
  input  logic [STEP_W-1:0] tstep_i,
  input  logic [STEP_W-1:0] wstep_i,
  input  logic [CNT_W-1:0]  wsize_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, wrap_addr;
  logic [CNT_W-1:0]  wcnt_q;

  // size casts of signed values sign-extend
  assign wrap_addr = base_q + ADDR_W'($signed(wstep_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      base_q <= '0;
      wcnt_q <= '0;
    end else if (clr_i) begin
      addr_o <= '0;
      base_q <= '0;
      wcnt_q <= '0;
    end else if (load_i) begin
      addr_o <= sh_addr_i;
      base_q <= sh_beg_i;
      wcnt_q <= wsize_i;
    end else if (word_step_i) begin
      addr_o <= addr_o + ADDR_W'($signed(bstep_i));
    end else if (burst_end_i) begin
      if (wcnt_q == '0) begin
        addr_o <= wrap_addr;
        base_q <= wrap_addr;
        wcnt_q <= wsize_i;
      end else begin
        addr_o <= addr_o + ADDR_W'($signed(tstep_i));
        wcnt_q <= wcnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl
  import dma_ch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hard_rst_i,
  input  logic             run_set_i,
  input  logic             pend_clr_i,
  input  logic             ovf_clr_i,
  input  logic             trig_i,
  input  mode_t            mode_i,
  input  logic [CNT_W-1:0] bsize_i,
  input  logic [CNT_W-1:0] tsize_i,
  output logic             load_o,
  output logic             word_step_o,
  output logic             burst_end_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             run_o,
  output logic             ovf_o,
  output logic             irq_o
);
  ch_state_e        state_q;
  logic             pend_q, in_xfer_q;
  logic [CNT_W-1:0] bcnt_q, tcnt_q;
  logic             consume, trig_hit;

  assign trig_hit    = trig_i && mode_i.trig_en;
  assign consume     = state_q == ST_ARMED && pend_q;
  assign load_o      = consume && !in_xfer_q;
  assign rd_o        = state_q == ST_RD;
  assign wr_o        = state_q == ST_WR;
  assign word_step_o = wr_o && bcnt_q != '0;
  assign burst_end_o = wr_o && bcnt_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; pend_q <= 1'b0; ovf_o <= 1'b0; run_o <= 1'b0;
      in_xfer_q <= 1'b0; irq_o <= 1'b0; bcnt_q <= '0; tcnt_q <= '0;
    end else if (hard_rst_i) begin
      state_q <= ST_IDLE; pend_q <= 1'b0; ovf_o <= 1'b0; run_o <= 1'b0;
      in_xfer_q <= 1'b0; irq_o <= 1'b0; bcnt_q <= '0; tcnt_q <= '0;
    end else begin
      irq_o <= 1'b0;
      if (pend_clr_i)   pend_q <= 1'b0;
      else if (trig_hit) pend_q <= 1'b1;
      else if (consume)  pend_q <= 1'b0;
      if (ovf_clr_i)                          ovf_o <= 1'b0;
      else if (trig_hit && pend_q && !consume) ovf_o <= 1'b1;

      unique case (state_q)
        ST_IDLE: if (run_set_i) begin
          run_o   <= 1'b1;
          state_q <= ST_ARMED;
        end
        ST_ARMED: if (pend_q) begin
          if (!in_xfer_q) begin
            in_xfer_q <= 1'b1;
            bcnt_q    <= bsize_i;
            tcnt_q    <= tsize_i;
            irq_o     <= mode_i.irq_en && !mode_i.at_end;
          end
          state_q <= ST_RD;
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (bcnt_q != '0) begin
            bcnt_q  <= bcnt_q - 1'b1;
            state_q <= ST_RD;
          end else begin
            bcnt_q <= bsize_i;
            if (tcnt_q != '0) begin
              tcnt_q  <= tcnt_q - 1'b1;
              state_q <= mode_i.oneshot ? ST_RD : ST_ARMED;
            end else begin
              in_xfer_q <= 1'b0;
              irq_o     <= mode_i.irq_en && mode_i.at_end;
              if (mode_i.cont) state_q <= ST_ARMED;
              else begin
                run_o   <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ch.sv
module dma_ch
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 16,
  parameter int STEP_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              trig_i,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wide_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              run_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              ovf_irq_o
);
  localparam int SRC = 0;
  localparam int DST = 1;

  logic run_set, hard_rst, pend_clr, ovf_clr;
  mode_t mode;
  logic [CNT_W-1:0] bsize, tsize;
  logic [1:0][STEP_W-1:0] bstep, tstep, wstep;
  logic [1:0][CNT_W-1:0]  wsize;
  logic [1:0][ADDR_W-1:0] sh_beg, sh_addr, side_addr;
  logic load, word_step, burst_end;
  logic [DATA_W-1:0] data_q;

  dma_ch_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .run_set_o(run_set), .hard_rst_o(hard_rst), .pend_clr_o(pend_clr),
    .ovf_clr_o(ovf_clr), .mode_o(mode), .bsize_o(bsize), .tsize_o(tsize),
    .bstep_o(bstep), .tstep_o(tstep), .wstep_o(wstep), .wsize_o(wsize),
    .sh_beg_o(sh_beg), .sh_addr_o(sh_addr)
  );

  dma_ch_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .hard_rst_i(hard_rst), .run_set_i(run_set),
    .pend_clr_i(pend_clr), .ovf_clr_i(ovf_clr), .trig_i, .mode_i(mode),
    .bsize_i(bsize), .tsize_i(tsize), .load_o(load), .word_step_o(word_step),
    .burst_end_o(burst_end), .rd_o(bus_rd_o), .wr_o(bus_wr_o), .run_o,
    .ovf_o, .irq_o
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_addr_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_side (
      .clk_i, .rst_ni, .clr_i(hard_rst), .load_i(load), .word_step_i(word_step),
      .burst_end_i(burst_end), .sh_beg_i(sh_beg[s]), .sh_addr_i(sh_addr[s]),
      .bstep_i(bstep[s]), .tstep_i(tstep[s]), .wstep_i(wstep[s]),
      .wsize_i(wsize[s]), .addr_o(side_addr[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       data_q <= '0;
    else if (bus_rd_o) data_q <= bus_rdata_i;
  end

  assign bus_addr_o  = bus_wr_o ? side_addr[DST] : side_addr[SRC];
  assign bus_wdata_o = data_q;
  assign bus_wide_o  = mode.wide;
  assign ovf_irq_o   = ovf_o && mode.ovf_ie;
endmodule

// File: rtl/dma_ch_chk.sv
module dma_ch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [3:0] reg_addr_i,
  input logic       hrst_bit_i,
  input logic       bus_rd_o,
  input logic       bus_wr_o,
  input logic       run_o,
  input logic       ovf_o,
  input logic       ovf_irq_o
);
  logic hrst_wr;
  assign hrst_wr = reg_we_i && reg_addr_i == 4'd0 && hrst_bit_i;

  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o && !hrst_wr |=> bus_wr_o); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |-> $past(bus_rd_o)); // R2
  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> !bus_rd_o && !bus_wr_o); // R9
  AST_HARD_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst_wr |=> !run_o && !ovf_o && !bus_rd_o && !bus_wr_o); // R12
  AST_OVF_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_o |-> ovf_o); // R11
endmodule

bind dma_ch dma_ch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .hrst_bit_i(reg_wdata_i[1]), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
  .run_o(run_o), .ovf_o(ovf_o), .ovf_irq_o(ovf_irq_o)
);

// File: tb/dma_ch_tb.sv
module dma_ch_tb;
  localparam int AW = 22;
  localparam int MASK = (1 << AW) - 1;
  localparam int TAG = 32'hA500_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0, trig_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic bus_rd_o, bus_wr_o, bus_wide_o, run_o, ovf_o, irq_o, ovf_irq_o;
  logic [AW-1:0] bus_addr_o;
  logic [31:0] bus_rdata_i, bus_wdata_o;

  always #4 clk_i = ~clk_i;
  assign bus_rdata_i = TAG | 32'(bus_addr_o);

  dma_ch u_dut (.*);

  int vec = 0, mis = 0, nwr = 0, nirq = 0;
  int wr_addr[256], wr_data[256];
  bit wr_wide[256];
  bit irq_rd, irq_after, prev_wr, done;
  int exp_a[2][64];

  always @(negedge clk_i) begin
    if (irq_o) begin nirq++; irq_rd = bus_rd_o; irq_after = prev_wr; end
    if (bus_wr_o && nwr < 256) begin
      wr_addr[nwr] = int'(bus_addr_o); wr_data[nwr] = int'(bus_wdata_o);
      wr_wide[nwr] = bus_wide_o; nwr++;
    end
    prev_wr = bus_wr_o;
  end

  task automatic chk(string r, int act, int exp);
    vec++;
    if (act != exp) begin
      mis++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    reg_we_i = 1'b1; reg_addr_i = 4'(a); reg_wdata_i = 32'(d);
    @(posedge clk_i); #1 reg_we_i = 1'b0;
  endtask

  task automatic trig();
    trig_i = 1'b1; @(posedge clk_i); #1 trig_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic cfg(int bsz, int tsz, int sbs, int dbs, int sts, int dts, int sws, int dws,
                     int swst, int dwst, int sbeg, int sadr, int dbeg, int dadr, int mode);
    wr_reg(0, 2);
    wr_reg(1, mode); wr_reg(2, bsz); wr_reg(3, tsz);
    wr_reg(4, sbs); wr_reg(5, dbs); wr_reg(6, sts); wr_reg(7, dts);
    wr_reg(8, sws); wr_reg(9, dws); wr_reg(10, swst); wr_reg(11, dwst);
    wr_reg(12, sbeg); wr_reg(13, sadr); wr_reg(14, dbeg); wr_reg(15, dadr);
  endtask

  // address model from the requirements
  task automatic gen(int s, int a0, int b0, int bs, int ts, int ws, int wst, int nw, int nb);
    int a = a0, b = b0, w = ws, k = 0;
    bs = int'(16'(bs)) << 16 >>> 16; ts = ts << 16 >>> 16; wst = wst << 16 >>> 16;
    for (int i = 0; i < nb; i++) begin
      for (int j = 0; j < nw; j++) begin
        exp_a[s][k] = a & MASK; k++;
        if (j < nw - 1) a = a + bs;
      end
      if (w == 0) begin b = b + wst; a = b; w = ws; end
      else begin w--; a = a + ts; end
    end
  endtask

  task automatic cmp(string r, int base, int n);
    for (int i = 0; i < n; i++) begin
      chk({r, " dst"}, wr_addr[base+i], exp_a[1][i]);
      chk({r, " data"}, wr_data[base+i], TAG | exp_a[0][i]);
    end
  endtask

  task automatic t_reset();
    chk("R1 run", int'(run_o), 0); chk("R1 ovf", int'(ovf_o), 0);
    chk("R1 irq", int'(irq_o | ovf_irq_o), 0); chk("R1 bus", int'(bus_rd_o | bus_wr_o), 0);
  endtask

  task automatic t_oneshot_linear();
    int b, q;
    cfg(3, 1, 1, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0, 'h100, 'h100, 'h200, 'h200, 51);
    b = nwr; q = nirq;
    wr_reg(0, 1); trig(); idle(40);
    chk("R3 R8 word count", nwr - b, 8);
    gen(0, 'h100, 'h100, 1, 1, 'hFFFF, 0, 4, 2); gen(1, 'h200, 'h200, 1, 1, 'hFFFF, 0, 4, 2);
    cmp("R2 R4 linear", b, 8);
    chk("R2 narrow", int'(wr_wide[b]), 0);
    chk("R9 run cleared", int'(run_o), 0);
    chk("R10 end irq count", nirq - q, 1);
    chk("R10 end irq after last write", int'(irq_after), 1);
  endtask

  task automatic t_per_burst();
    int b, q;
    cfg(3, 1, 1, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0, 'h100, 'h100, 'h200, 'h200, 49);
    b = nwr; q = nirq;
    wr_reg(0, 1); trig(); idle(30);
    chk("R8 one burst per trigger", nwr - b, 4);
    chk("R8 still running", int'(run_o), 1);
    trig(); idle(30);
    chk("R8 second burst", nwr - b, 8);
    chk("R9 run cleared", int'(run_o), 0);
    chk("R10 one irq per transfer", nirq - q, 1);
  endtask

  task automatic t_wrap_negative();
    int b, q;
    cfg(1, 4, 1, -1, 10, -3, 1, 'hFFFF, 'h20, 0, 'h300, 'h300, 5, 5, 3);
    b = nwr; q = nirq;
    wr_reg(0, 1); trig(); idle(40);
    chk("R3 count", nwr - b, 10);
    gen(0, 'h300, 'h300, 1, 10, 1, 'h20, 2, 5); gen(1, 5, 5, -1, -3, 'hFFFF, 0, 2, 5);
    cmp("R5 R6 wrap", b, 10);
    chk("R6 wrap replaces transfer step", wr_data[b+4], TAG | 'h320);
    chk("R5 negative rollover", wr_addr[b+4], 'h3FFFFD);
    chk("R10 irq disabled", nirq - q, 0);
  endtask

  task automatic t_shadow();
    int b;
    cfg(1, 1, 1, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0, 'h400, 'h400, 'h500, 'h500, 1);
    b = nwr;
    wr_reg(0, 1); trig(); idle(20);
    wr_reg(12, 'h600); wr_reg(13, 'h600); wr_reg(14, 'h700); wr_reg(15, 'h700);
    trig(); idle(20);
    chk("R7 mid-transfer shadow ignored", wr_addr[b+2], 'h502);
    chk("R7 mid-transfer shadow ignored data", wr_data[b+3], TAG | 'h403);
    wr_reg(0, 1); trig(); idle(20);
    chk("R7 shadow at start dst", wr_addr[b+4], 'h700);
    chk("R7 shadow at start src", wr_data[b+4], TAG | 'h600);
  endtask

  task automatic t_continuous();
    int b;
    cfg(1, 0, 1, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0, 'h880, 'h880, 'h800, 'h800, 7);
    b = nwr;
    wr_reg(0, 1); trig(); idle(20);
    chk("R9 continuous stays armed", int'(run_o), 1);
    trig(); idle(20);
    chk("R9 restart count", nwr - b, 4);
    chk("R9 restart from shadow", wr_addr[b+2], 'h800);
    chk("R9 restart src", wr_data[b+3], TAG | 'h881);
  endtask

  task automatic t_wide_start_irq();
    int b, q;
    cfg(1, 1, 2, 2, 2, 2, 'hFFFF, 'hFFFF, 0, 0, 'hA00, 'hA00, 'h900, 'h900, 1+2+8+16);
    b = nwr; q = nirq;
    wr_reg(0, 1); trig(); idle(30);
    gen(0, 'hA00, 'hA00, 2, 2, 'hFFFF, 0, 2, 2); gen(1, 'h900, 'h900, 2, 2, 'hFFFF, 0, 2, 2);
    cmp("R2 wide steps", b, 4);
    chk("R2 wide flag", int'(wr_wide[b] & wr_wide[b+3]), 1);
    chk("R10 start irq count", nirq - q, 1);
    chk("R10 start irq with first read", int'(irq_rd), 1);
  endtask

  task automatic t_overflow();
    int b;
    cfg(0, 0, 1, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0, 'hB00, 'hB00, 'hC00, 'hC00, 1 + 64);
    b = nwr;
    trig();
    chk("R11 single trigger no ovf", int'(ovf_o), 0);
    trig();
    chk("R11 ovf set", int'(ovf_o), 1);
    chk("R11 ovf irq enabled", int'(ovf_irq_o), 1);
    wr_reg(0, 8);
    chk("R11 ovf cleared", int'(ovf_o), 0);
    wr_reg(1, 1); trig();
    chk("R11 ovf set again", int'(ovf_o), 1);
    chk("R11 ovf irq masked", int'(ovf_irq_o), 0);
    wr_reg(0, 12);
    wr_reg(0, 1); idle(20);
    chk("R11 pending discarded", nwr - b, 0);
    wr_reg(1, 2); trig(); idle(20);
    chk("R13 trigger gated off", nwr - b, 0);
    wr_reg(1, 3); trig(); idle(20);
    chk("R13 trigger enabled moves word", nwr - b, 1);
  endtask

  task automatic t_hard_reset();
    int b, m;
    cfg(7, 3, 1, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0, 'hD00, 'hD00, 'hE00, 'hE00, 3);
    b = nwr;
    wr_reg(0, 1); trig(); idle(6);
    trig(); trig();
    wr_reg(0, 2);
    m = nwr; idle(30);
    chk("R12 run cleared", int'(run_o), 0);
    chk("R12 ovf cleared", int'(ovf_o), 0);
    chk("R12 bus stopped", nwr - m, 0);
    chk("R12 partial transfer", int'(nwr - b < 32), 1);
    wr_reg(0, 1); idle(20);
    chk("R12 no stale trigger", nwr - m, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      mis++; vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1'b1; idle(2);
    t_reset();
    t_oneshot_linear();
    t_per_burst();
    t_wrap_negative();
    t_shadow();
    t_continuous();
    t_wide_start_irq();
    t_overflow();
    t_hard_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule